// File: doc/BRIEF.md
# Load Ordering Check with Store Forwarding

This block sits in the memory pipeline of an out-of-order core. It decides whether a load may run ahead of the stores that precede it in program order. Each load arrives with its address, its own load tag, and a store color: the highest store-buffer ID that existed when the load was allocated. The block compares the load only against store-buffer entries at or below that color, using a snapshot of the store buffer's valid, address-known and data-known flags, addresses and data. It returns one of three outcomes. The load proceeds to the cache, the load takes its data straight from a matching older store, or the load blocks with a reason code.

A blocked load is kept in a small table indexed by its load tag. The table also records which store the load waits on. When a store-write notice names that store, meaning its address or its data was just written, the load becomes ready. Ready loads are sent back into the check stage one per cycle, oldest tag first. A re-sent load skips the address stage. Loads arriving fresh from address generation take the check stage before any re-sent load.

Top module: `ld_order_check`

## Requirements
- R1: Only store entries that are valid and whose ID is not above the load's color are considered. Entries above the color and invalid entries never change the outcome.
- R2: If any considered store has its address unknown, the result code is 1 (address wait). This takes priority over any address match. The load then waits on the lowest-numbered such store.
- R3: Otherwise, if the youngest considered store with an equal address has its data unknown, the result code is 2 (data wait). The load then waits on that store.
- R4: Otherwise, if the youngest considered store with an equal address has data known, the result code is 0 with `res_fwd`=1, and `res_data` equals that store's data.
- R5: With no considered store matching and none unresolved, the result code is 0 with `res_fwd`=0 and `res_data`=0.
- R6: A load presented at one rising edge produces its result, with `res_vld`=1, at the second rising edge after it. After reset, `res_vld` is 0.
- R7: A blocked load is held until a store-write notice carries the ID it waits on. A notice for any other ID leaves it blocked. Once ready, it enters the check stage at the next edge, skipping address generation, and its result shows `res_retry`=1.
- R8: At most one held load is re-sent per cycle. Among ready loads, the lowest load tag goes first.
- R9: When a fresh load and a ready held load compete in the same cycle, the fresh load is checked first. The held load follows on a later cycle.
- R10: A store-write notice that arrives in the same cycle as the check that blocks the load still wakes that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | Fresh load with computed address present |
| iss_lid | input | LIDW (2) | Load tag, lower is older |
| iss_color | input | SIDW (2) | Store color captured at allocation |
| iss_addr | input | AW (8) | Load address |
| sb_vld | input | SB_N (4) | Store entry valid, one bit per store ID |
| sb_aok | input | SB_N (4) | Store address known |
| sb_dok | input | SB_N (4) | Store data known |
| sb_addr | input | SB_N*AW (32) | Store addresses, ID i at bits i*AW |
| sb_data | input | SB_N*DW (32) | Store data, ID i at bits i*DW |
| wk_vld | input | 1 | Store-write notice valid |
| wk_sid | input | SIDW (2) | Store ID that was written |
| res_vld | output | 1 | Check result valid |
| res_lid | output | LIDW (2) | Tag of the checked load |
| res_code | output | 2 | 0 go, 1 address wait, 2 data wait |
| res_fwd | output | 1 | Data forwarded from a store |
| res_data | output | DW (8) | Forwarded data, zero otherwise |
| res_retry | output | 1 | Result belongs to a re-sent load |

## Verification
A fresh load and a re-send of a held load can both want the check stage in one cycle. The bench sets this up by blocking two loads on the same store and waking them together. It then presents a new load exactly in the cycle where the older held load would be picked. It judges the outcome by the order and timing of the three results: the fresh load first with retry clear, then the two held loads in tag order with retry set. A second collision puts the wakeup notice in the very cycle of the blocking check. The bench expects the load to come back without any further notice.

// File: rtl/ld_order_pkg.sv
package ld_order_pkg;

  typedef enum logic [1:0] {
    CHK_GO        = 2'd0,
    CHK_ADDR_WAIT = 2'd1,
    CHK_DATA_WAIT = 2'd2
  } chk_code_e;

  // store with ID sid is program-order older than (or equal to) the color
  function automatic logic older_or_same(input int unsigned sid, input int unsigned color);
    return sid <= color;
  endfunction

  // address equality for a resolved store
  function automatic logic addr_hit(input logic aok, input logic [31:0] sa, input logic [31:0] la);
    return aok && (sa == la);
  endfunction

endpackage

// File: rtl/ld_order_match.sv
module ld_order_match
  import ld_order_pkg::*;
#(
  parameter int SB_N = 4,
  parameter int AW   = 8,
  parameter int DW   = 8,
  localparam int SIDW = $clog2(SB_N)
) (
  input  logic [AW-1:0]      ld_addr,
  input  logic [SIDW-1:0]    ld_color,
  input  logic [SB_N-1:0]    sb_vld,
  input  logic [SB_N-1:0]    sb_aok,
  input  logic [SB_N-1:0]    sb_dok,
  input  logic [SB_N*AW-1:0] sb_addr,
  input  logic [SB_N*DW-1:0] sb_data,
  output chk_code_e          code,
  output logic [SIDW-1:0]    wsid,
  output logic               fwd,
  output logic [DW-1:0]      fwd_data
);

  logic [SB_N-1:0] rel;
  logic [SB_N-1:0] eq;
  logic            unres;
  logic [SIDW-1:0] unres_sid;
  logic            hit;
  logic [SIDW-1:0] hit_sid;

  for (genvar g = 0; g < SB_N; g++) begin : g_ent
    assign rel[g] = sb_vld[g] && older_or_same(g, int'(ld_color));
    assign eq[g]  = rel[g] && addr_hit(sb_aok[g], 32'(sb_addr[g*AW +: AW]), 32'(ld_addr));
  end

  always_comb begin
    unres     = 1'b0;
    unres_sid = '0;
    for (int i = SB_N - 1; i >= 0; i--) begin
      if (rel[i] && !sb_aok[i]) begin
        unres     = 1'b1;
        unres_sid = SIDW'(i);
      end
    end
    hit     = 1'b0;
    hit_sid = '0;
    for (int i = 0; i < SB_N; i++) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_sid = SIDW'(i);
      end
    end
  end

  always_comb begin
    if (unres)                        code = CHK_ADDR_WAIT;
    else if (hit && !sb_dok[hit_sid]) code = CHK_DATA_WAIT;
    else                              code = CHK_GO;
    wsid     = unres ? unres_sid : hit_sid;
    fwd      = !unres && hit && sb_dok[hit_sid];
    fwd_data = fwd ? sb_data[int'(hit_sid)*DW +: DW] : '0;
  end

endmodule

// File: rtl/ld_order_table.sv
module ld_order_table #(
  parameter int LD_N = 4,
  parameter int SB_N = 4,
  parameter int AW   = 8,
  localparam int LIDW = $clog2(LD_N),
  localparam int SIDW = $clog2(SB_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_vld,
  input  logic [LIDW-1:0] alloc_lid,
  input  logic [AW-1:0]   alloc_addr,
  input  logic [SIDW-1:0] alloc_color,
  input  logic [SIDW-1:0] alloc_wsid,
  input  logic            wk_vld,
  input  logic [SIDW-1:0] wk_sid,
  input  logic            take,
  output logic            pick_vld,
  output logic [LIDW-1:0] pick_lid,
  output logic [AW-1:0]   pick_addr,
  output logic [SIDW-1:0] pick_color
);

  logic [LD_N-1:0] occ;
  logic [LD_N-1:0] rdy;
  logic [AW-1:0]   e_addr [LD_N];
  logic [SIDW-1:0] e_col  [LD_N];
  logic [SIDW-1:0] e_wsid [LD_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      rdy <= '0;
      for (int i = 0; i < LD_N; i++) begin
        e_addr[i] <= '0;
        e_col[i]  <= '0;
        e_wsid[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LD_N; i++) begin
        if (alloc_vld && alloc_lid == LIDW'(i)) begin
          occ[i]    <= 1'b1;
          rdy[i]    <= wk_vld && (wk_sid == alloc_wsid);
          e_addr[i] <= alloc_addr;
          e_col[i]  <= alloc_color;
          e_wsid[i] <= alloc_wsid;
        end else if (take && pick_lid == LIDW'(i)) begin
          occ[i] <= 1'b0;
          rdy[i] <= 1'b0;
        end else if (occ[i] && wk_vld && wk_sid == e_wsid[i]) begin
          rdy[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    pick_vld = 1'b0;
    pick_lid = '0;
    for (int i = LD_N - 1; i >= 0; i--) begin
      if (occ[i] && rdy[i]) begin
        pick_vld = 1'b1;
        pick_lid = LIDW'(i);
      end
    end
  end

  assign pick_addr  = e_addr[pick_lid];
  assign pick_color = e_col[pick_lid];

  assert_alloc_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |-> !occ[alloc_lid]);

  assert_take_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (occ[pick_lid] && rdy[pick_lid]));

  assert_take_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !occ[$past(pick_lid)]);

endmodule

// File: rtl/ld_order_check.sv
module ld_order_check
  import ld_order_pkg::*;
#(
  parameter int SB_N = 4,
  parameter int LD_N = 4,
  parameter int AW   = 8,
  parameter int DW   = 8,
  localparam int SIDW = $clog2(SB_N),
  localparam int LIDW = $clog2(LD_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_vld,
  input  logic [LIDW-1:0]    iss_lid,
  input  logic [SIDW-1:0]    iss_color,
  input  logic [AW-1:0]      iss_addr,
  input  logic [SB_N-1:0]    sb_vld,
  input  logic [SB_N-1:0]    sb_aok,
  input  logic [SB_N-1:0]    sb_dok,
  input  logic [SB_N*AW-1:0] sb_addr,
  input  logic [SB_N*DW-1:0] sb_data,
  input  logic               wk_vld,
  input  logic [SIDW-1:0]    wk_sid,
  output logic               res_vld,
  output logic [LIDW-1:0]    res_lid,
  output logic [1:0]         res_code,
  output logic               res_fwd,
  output logic [DW-1:0]      res_data,
  output logic               res_retry
);

  // check stage
  logic            s2_vld;
  logic [LIDW-1:0] s2_lid;
  logic [SIDW-1:0] s2_color;
  logic [AW-1:0]   s2_addr;
  logic            s2_retry;

  // named internal events
  logic            tbl_pick_vld;
  logic [LIDW-1:0] tbl_pick_lid;
  logic [AW-1:0]   tbl_pick_addr;
  logic [SIDW-1:0] tbl_pick_color;
  logic            tbl_take;
  logic            blk_alloc;
  chk_code_e       chk_code;
  logic [SIDW-1:0] chk_wsid;
  logic            chk_fwd;
  logic [DW-1:0]   chk_data;
  chk_code_e       s3_code;

  assign tbl_take  = tbl_pick_vld && !iss_vld;
  assign blk_alloc = s2_vld && (chk_code != CHK_GO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld   <= 1'b0;
      s2_lid   <= '0;
      s2_color <= '0;
      s2_addr  <= '0;
      s2_retry <= 1'b0;
    end else if (iss_vld) begin
      s2_vld   <= 1'b1;
      s2_lid   <= iss_lid;
      s2_color <= iss_color;
      s2_addr  <= iss_addr;
      s2_retry <= 1'b0;
    end else if (tbl_take) begin
      s2_vld   <= 1'b1;
      s2_lid   <= tbl_pick_lid;
      s2_color <= tbl_pick_color;
      s2_addr  <= tbl_pick_addr;
      s2_retry <= 1'b1;
    end else begin
      s2_vld   <= 1'b0;
      s2_retry <= 1'b0;
    end
  end

  ld_order_match #(.SB_N(SB_N), .AW(AW), .DW(DW)) u_match (
    .ld_addr  (s2_addr),
    .ld_color (s2_color),
    .sb_vld   (sb_vld),
    .sb_aok   (sb_aok),
    .sb_dok   (sb_dok),
    .sb_addr  (sb_addr),
    .sb_data  (sb_data),
    .code     (chk_code),
    .wsid     (chk_wsid),
    .fwd      (chk_fwd),
    .fwd_data (chk_data)
  );

  ld_order_table #(.LD_N(LD_N), .SB_N(SB_N), .AW(AW)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_vld   (blk_alloc),
    .alloc_lid   (s2_lid),
    .alloc_addr  (s2_addr),
    .alloc_color (s2_color),
    .alloc_wsid  (chk_wsid),
    .wk_vld      (wk_vld),
    .wk_sid      (wk_sid),
    .take        (tbl_take),
    .pick_vld    (tbl_pick_vld),
    .pick_lid    (tbl_pick_lid),
    .pick_addr   (tbl_pick_addr),
    .pick_color  (tbl_pick_color)
  );

  // result stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_lid   <= '0;
      s3_code   <= CHK_GO;
      res_fwd   <= 1'b0;
      res_data  <= '0;
      res_retry <= 1'b0;
    end else begin
      res_vld   <= s2_vld;
      res_lid   <= s2_vld ? s2_lid : '0;
      s3_code   <= s2_vld ? chk_code : CHK_GO;
      res_fwd   <= s2_vld && chk_fwd;
      res_data  <= s2_vld ? chk_data : '0;
      res_retry <= s2_vld && s2_retry;
    end
  end

  assign res_code = s3_code;

  assert_addr_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && chk_code == CHK_ADDR_WAIT) |->
      (sb_vld[chk_wsid] && !sb_aok[chk_wsid] && chk_wsid <= s2_color));

  assert_data_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && chk_code == CHK_DATA_WAIT) |->
      (sb_aok[chk_wsid] && !sb_dok[chk_wsid] && sb_addr[int'(chk_wsid)*AW +: AW] == s2_addr));

  assert_fwd_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_fwd) |-> (res_code == 2'd0));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld |=> ##1 (res_vld && !res_retry));

  assert_retry_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_take |=> (s2_vld && s2_retry));

  assert_fresh_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && tbl_pick_vld) |=> (s2_vld && !s2_retry && s2_lid == $past(iss_lid)));

endmodule

// File: tb/ld_order_check_bench.sv
`timescale 1ns/1ps
module ld_order_check_bench;

  localparam logic [7:0] LA = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_vld;
  logic [1:0]  iss_lid;
  logic [1:0]  iss_color;
  logic [7:0]  iss_addr;
  logic [3:0]  sb_vld, sb_aok, sb_dok;
  logic [31:0] sb_addr, sb_data;
  logic        wk_vld;
  logic [1:0]  wk_sid;
  logic        res_vld;
  logic [1:0]  res_lid;
  logic [1:0]  res_code;
  logic        res_fwd;
  logic [7:0]  res_data;
  logic        res_retry;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ld_order_check u_ld_order_check (
    .clk(clk), .rst_n(rst_n),
    .iss_vld(iss_vld), .iss_lid(iss_lid), .iss_color(iss_color), .iss_addr(iss_addr),
    .sb_vld(sb_vld), .sb_aok(sb_aok), .sb_dok(sb_dok), .sb_addr(sb_addr), .sb_data(sb_data),
    .wk_vld(wk_vld), .wk_sid(wk_sid),
    .res_vld(res_vld), .res_lid(res_lid), .res_code(res_code), .res_fwd(res_fwd),
    .res_data(res_data), .res_retry(res_retry)
  );

  function automatic logic [14:0] pack_res();
    return {res_vld, res_lid, res_code, res_fwd, res_data, res_retry};
  endfunction

  function automatic logic [14:0] want(input logic [1:0] lid, input int code,
                                       input logic fwd, input logic [7:0] d, input logic retry);
    return {1'b1, lid, 2'(code), fwd, d, retry};
  endfunction

  function automatic logic [7:0] st_data(input int s);
    return 8'(8'hA0 + 17 * s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sb_clear();
    sb_vld = '0; sb_aok = '0; sb_dok = '0; sb_addr = '0; sb_data = '0;
  endtask

  // state per store: 0 invalid, 1 addr unknown, 2 match data unknown,
  // 3 match data known, 4 other address data known
  task automatic run_case(input int c, input int st [4], input logic [1:0] lid);
    int    ecode = 0;
    int    ews = 0;
    logic  efwd = 1'b0;
    logic [7:0] ed = 8'h00;
    bit    un = 0;
    int    y = -1;
    string tag;
    for (int s = 0; s < 4; s++) begin
      sb_vld[s] = (st[s] != 0);
      sb_aok[s] = (st[s] >= 2);
      sb_dok[s] = (st[s] >= 3);
      sb_addr[s*8 +: 8] = (st[s] == 4) ? 8'(8'h41 + s) : LA;
      sb_data[s*8 +: 8] = st_data(s);
    end
    for (int s = 0; s <= c; s++)
      if (st[s] == 1 && !un) begin un = 1; ews = s; end
    if (un) ecode = 1;
    else begin
      for (int s = 0; s <= c; s++) if (st[s] == 2 || st[s] == 3) y = s;
      if (y >= 0 && st[y] == 2) begin ecode = 2; ews = y; end
      else if (y >= 0) begin efwd = 1'b1; ed = st_data(y); end
    end
    tag = (ecode == 1) ? "R2" : (ecode == 2) ? "R3" : efwd ? "R4" : "R5";
    iss_vld = 1'b1; iss_lid = lid; iss_color = 2'(c); iss_addr = LA;
    @(negedge clk); iss_vld = 1'b0;
    @(negedge clk);
    check(tag, 32'(pack_res()), 32'(want(lid, ecode, efwd, ed, 1'b0)));
    if (ecode != 0) begin
      wk_vld = 1'b1; wk_sid = 2'(ews ^ 1);
      @(negedge clk); wk_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R7 wrong id no wake", 32'(res_vld), 32'(0));
      sb_clear();
      wk_vld = 1'b1; wk_sid = 2'(ews);
      @(negedge clk); wk_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R7 retry", 32'(pack_res()), 32'(want(lid, 0, 1'b0, 8'h00, 1'b1)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int st [4];
    rst_n = 1'b0; iss_vld = 1'b0; iss_lid = '0; iss_color = '0; iss_addr = '0;
    wk_vld = 1'b0; wk_sid = '0;
    sb_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R6 reset", 32'(res_vld), 32'(0));

    // R6: latency of two edges
    iss_vld = 1'b1; iss_lid = 2'd1; iss_color = 2'd3; iss_addr = LA;
    @(negedge clk); iss_vld = 1'b0;
    check("R6 not early", 32'(res_vld), 32'(0));
    @(negedge clk);
    check("R6 on time", 32'(pack_res()), 32'(want(2'd1, 0, 1'b0, 8'h00, 1'b0)));

    // R1: younger entries ignored
    st[0] = 0; st[1] = 1; st[2] = 3; st[3] = 2;
    for (int s = 0; s < 4; s++) begin
      sb_vld[s] = (st[s] != 0); sb_aok[s] = (st[s] >= 2); sb_dok[s] = (st[s] >= 3);
      sb_addr[s*8 +: 8] = LA; sb_data[s*8 +: 8] = st_data(s);
    end
    iss_vld = 1'b1; iss_lid = 2'd2; iss_color = 2'd0; iss_addr = LA;
    @(negedge clk); iss_vld = 1'b0;
    @(negedge clk);
    check("R1", 32'(pack_res()), 32'(want(2'd2, 0, 1'b0, 8'h00, 1'b0)));
    sb_clear();

    // sweep all store states for every color
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 625; k++) begin
        int q = k;
        for (int s = 0; s < 4; s++) begin st[s] = q % 5; q = q / 5; end
        run_case(c, st, 2'(k));
      end
    end
    sb_clear();

    // R8 / R9: two held loads plus a fresh load competing
    sb_vld[0] = 1'b1; sb_aok[0] = 1'b0;
    iss_vld = 1'b1; iss_lid = 2'd1; iss_color = 2'd0; iss_addr = LA;
    @(negedge clk); iss_lid = 2'd0;
    @(negedge clk); iss_vld = 1'b0;
    check("R2 hold a", 32'(pack_res()), 32'(want(2'd1, 1, 1'b0, 8'h00, 1'b0)));
    @(negedge clk);
    check("R2 hold b", 32'(pack_res()), 32'(want(2'd0, 1, 1'b0, 8'h00, 1'b0)));
    sb_aok[0] = 1'b1; sb_dok[0] = 1'b1; sb_addr[7:0] = 8'h55;
    wk_vld = 1'b1; wk_sid = 2'd0;
    @(negedge clk); wk_vld = 1'b0;
    iss_vld = 1'b1; iss_lid = 2'd2; iss_color = 2'd0; iss_addr = LA;
    @(negedge clk); iss_vld = 1'b0;
    @(negedge clk);
    check("R9 fresh first", 32'(pack_res()), 32'(want(2'd2, 0, 1'b0, 8'h00, 1'b0)));
    @(negedge clk);
    check("R8 oldest", 32'(pack_res()), 32'(want(2'd0, 0, 1'b0, 8'h00, 1'b1)));
    @(negedge clk);
    check("R8 next", 32'(pack_res()), 32'(want(2'd1, 0, 1'b0, 8'h00, 1'b1)));
    @(negedge clk);
    check("R8 one each", 32'(res_vld), 32'(0));
    sb_clear();

    // R10: wakeup in the cycle of the blocking check
    sb_vld[0] = 1'b1;
    iss_vld = 1'b1; iss_lid = 2'd3; iss_color = 2'd0; iss_addr = LA;
    @(negedge clk); iss_vld = 1'b0;
    wk_vld = 1'b1; wk_sid = 2'd0;
    @(negedge clk); wk_vld = 1'b0;
    check("R10 block", 32'(pack_res()), 32'(want(2'd3, 1, 1'b0, 8'h00, 1'b0)));
    sb_clear();
    @(negedge clk);
    @(negedge clk);
    check("R10 woken", 32'(pack_res()), 32'(want(2'd3, 0, 1'b0, 8'h00, 1'b1)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule